// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block gathers the data bytes of one serial write session into a small page buffer. Then, on the session's STOP, it copies them into the byte array in one timed internal write cycle. The bus front end hands it three things: a start address, one strobe per received data byte, and a STOP strobe. It also reports a new START and a write-protect refusal. The block turns these into array writes and a busy flag. The front end uses the busy flag to refuse new commands until the write has finished.

The start address splits into two parts. The upper bits pick a page and stay fixed for the session. The low bits pick a slot inside the page and step by one per byte, wrapping back to slot 0 after the last slot, so a long burst overwrites earlier slots. A per-slot mask records which slots were filled. Only those slots are stored at commit time. The mask is cleared when the write cycle ends.

After reset the block is busy for a power-up delay of `PU_CYCLES` cycles. A commit then holds busy for `WR_CYCLES` cycles. Both delays are modelled with one counter. The array itself comes out of reset erased, and a read port gives access to it.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset is released, busy stays high for PU_CYCLES cycles and then falls; no command is taken during that time.
- R2: After reset every array location reads 8'hFF.
- R3: The page part of the address (bits ADDR_W-1 down to 4 for 16 slots) is taken from base_addr when load_base is pulsed; each accepted byte goes to that page at the current slot, and the slot then advances by one.
- R4: After slot 15 the slot pointer wraps to slot 0 of the same page, and a byte loaded into an already filled slot replaces the earlier byte.
- R5: A STOP with at least one byte loaded starts a write cycle. Busy is high for exactly WR_CYCLES cycles, beginning the cycle after the STOP. Afterwards each loaded byte reads back at its address.
- R6: The commit writes only the slots that were loaded, one array write per loaded slot; other locations in the page keep their earlier contents.
- R7: A STOP with no bytes loaded (address-only header) does not raise busy and performs no array write.
- R8: sess_start before STOP discards the loaded bytes; a later STOP writes nothing.
- R9: wp_abort discards the loaded bytes, and the array stays unchanged.
- R10: While busy, load_base, byte_stb, stop_stb, sess_start and wp_abort are ignored; bytes offered during a commit are never written.
- R11: A byte strobe in the same cycle as stop_stb is loaded and is included in that commit.
- R12: A byte strobe in the same cycle as sess_start or wp_abort is dropped together with the rest of the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_start | input | 1 | A new START was seen; abandon the buffer |
| load_base | input | 1 | Latch base_addr as page and slot pointer |
| base_addr | input | ADDR_W | Start address of the session |
| byte_stb | input | 1 | One data byte received |
| byte_data | input | DATA_W | Data byte |
| stop_stb | input | 1 | STOP seen; commit if anything is loaded |
| wp_abort | input | 1 | Write refused by protection; abandon the buffer |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |
| busy | output | 1 | Power-up delay or write cycle in progress |
| mem_we | output | 1 | Array write strobe during commit |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
Two pairs of events can fall in the same cycle. The first is the last data byte arriving together with STOP. The second is a byte arriving together with a START or a write-protect refusal. The bench provokes each pair by raising both strobes in one cycle. For the STOP pair, it checks that the coinciding byte reads back from the array after the write cycle. For the START or refusal pair, it checks three things: busy stays low after a following STOP, no array write takes place, and the address still reads 8'hFF.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    CS_POWERUP = 2'd0,
    CS_IDLE    = 2'd1,
    CS_COMMIT  = 2'd2
  } commit_state_e;
endpackage

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];

  // R5: a write strobe leaves its data at its address
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cell_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     load_base,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic                     byte_stb,
  input  logic [DATA_W-1:0]        byte_data,
  input  logic                     clear,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic [ADDR_W-$clog2(SLOTS)-1:0] page_base,
  output logic [SLOTS-1:0]         valid_mask,
  output logic [DATA_W-1:0]        slot_data
);
  localparam int OFS_W  = $clog2(SLOTS);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFS_W-1:0]  ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] data_q [SLOTS];
  logic              base_en, byte_en;

  assign base_en = accept && load_base;
  assign byte_en = accept && byte_stb && !clear;

  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (base_en) begin
      page_d = base_addr[ADDR_W-1:OFS_W];
      ptr_d  = base_addr[OFS_W-1:0];
    end else if (byte_en) begin
      ptr_d = ptr_q + OFS_W'(1);
    end
    if (clear) begin
      mask_d = '0;
    end else if (byte_en) begin
      mask_d = mask_q | (SLOTS'(1) << ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic slot_en;
    assign slot_en = byte_en && (ptr_q == OFS_W'(s));
    always_ff @(posedge clk) begin
      if (slot_en) data_q[s] <= byte_data;
    end
  end

  assign page_base  = page_q;
  assign valid_mask = mask_q;
  assign slot_data  = data_q[rd_slot];

  // R4: the slot pointer wraps within the page
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !base_en && ptr_q == OFS_W'(SLOTS-1)) |=> ptr_q == '0);

  // R3: the page stays put while bytes stream in
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_en) |=> $stable(page_q));

  // R8: a clear leaves no slot marked
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> mask_q == '0);
endmodule

// File: rtl/pwb_commit_ctl.sv
module pwb_commit_ctl
  import pwb_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PU_CYCLES = 50000,
  parameter int WR_CYCLES = 250000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stop_stb,
  input  logic                     start_stb,
  input  logic                     wp_abort,
  input  logic                     any_pending,
  input  logic [SLOTS-1:0]         scan_mask,
  output logic                     accept,
  output logic                     busy,
  output logic                     buf_clear,
  output logic [$clog2(SLOTS)-1:0] scan_slot,
  output logic                     scan_we
);
  localparam int OFS_W = $clog2(SLOTS);
  localparam int MAX_C = (PU_CYCLES > WR_CYCLES) ? PU_CYCLES : WR_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1) > OFS_W + 1 ? $clog2(MAX_C + 1) : OFS_W + 1;

  commit_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pu_last, wr_last, commit_go;

  assign accept    = (state_q == CS_IDLE);
  assign busy      = !accept;
  assign pu_last   = (state_q == CS_POWERUP) && (cnt_q == CNT_W'(PU_CYCLES - 1));
  assign wr_last   = (state_q == CS_COMMIT)  && (cnt_q == CNT_W'(WR_CYCLES - 1));
  assign commit_go = accept && stop_stb && any_pending;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CS_POWERUP: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (pu_last) begin
          state_d = CS_IDLE;
          cnt_d   = '0;
        end
      end
      CS_IDLE: begin
        if (commit_go) begin
          state_d = CS_COMMIT;
          cnt_d   = '0;
        end
      end
      CS_COMMIT: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (wr_last) begin
          state_d = CS_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = CS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_POWERUP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scan_slot = cnt_q[OFS_W-1:0];
  assign scan_we   = (state_q == CS_COMMIT) && (cnt_q < CNT_W'(SLOTS)) && scan_mask[scan_slot];
  assign buf_clear = (accept && (start_stb || wp_abort)) || wr_last;

  // R7: a STOP with nothing loaded never raises busy
  p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stop_stb && !any_pending) |=> !busy);

  // R5: a running write cycle is not cut short
  p_commit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_COMMIT && !wr_last) |=> busy);

  // R6: array writes happen only inside a write cycle
  p_we_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_we |-> busy);

  // R1: the power-up delay ends only into the idle state
  p_pu_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pu_last |=> accept);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int SLOTS     = 16,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int PU_CYCLES = 50000,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_start,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_stb,
  input  logic              wp_abort,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFS_W  = $clog2(SLOTS);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              accept, buf_clear, any_pending;
  logic [OFS_W-1:0]  scan_slot;
  logic [PAGE_W-1:0] page_base;
  logic [SLOTS-1:0]  valid_mask;

  assign any_pending = (|valid_mask) || (byte_stb && !sess_start && !wp_abort);

  pwb_page_buf #(
    .SLOTS (SLOTS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .load_base (load_base),
    .base_addr (base_addr),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .clear     (buf_clear),
    .rd_slot   (scan_slot),
    .page_base (page_base),
    .valid_mask(valid_mask),
    .slot_data (mem_wdata)
  );

  pwb_commit_ctl #(
    .SLOTS    (SLOTS),
    .PU_CYCLES(PU_CYCLES),
    .WR_CYCLES(WR_CYCLES)
  ) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_stb   (stop_stb),
    .start_stb  (sess_start),
    .wp_abort   (wp_abort),
    .any_pending(any_pending),
    .scan_mask  (valid_mask),
    .accept     (accept),
    .busy       (busy),
    .buf_clear  (buf_clear),
    .scan_slot  (scan_slot),
    .scan_we    (mem_we)
  );

  assign mem_addr = {page_base, scan_slot};

  pwb_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_arr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(mem_addr),
    .wdata(mem_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // R10: nothing entered while busy changes the buffer mask
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_stb) |=> (valid_mask == '0 || $stable(valid_mask)));
endmodule

// File: tb/test_page_commit_ctrl.sv
`timescale 1ns/1ps
module test_page_commit_ctrl;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int PU = 20;
  localparam int WR = 40;

  logic clk, rst_n;
  logic sess_start, load_base, byte_stb, stop_stb, wp_abort;
  logic [AW-1:0] base_addr, rd_addr, mem_addr;
  logic [DW-1:0] byte_data, rd_data, mem_wdata;
  logic busy, mem_we;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  bit finished = 0;

  page_commit_ctrl #(
    .SLOTS(16), .ADDR_W(AW), .DATA_W(DW), .PU_CYCLES(PU), .WR_CYCLES(WR)
  ) i_page_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .load_base(load_base),
    .base_addr(base_addr), .byte_stb(byte_stb), .byte_data(byte_data),
    .stop_stb(stop_stb), .wp_abort(wp_abort), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && mem_we) we_cnt++;

  // op: 0 base, 1 byte, 2 stop, 3 read-compare  {op[1:0], val[8:0], exp[7:0]}
  localparam int NV = 19;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 9'h023, 8'h00},  // R3 base
    {2'd1, 9'h011, 8'h00},
    {2'd1, 9'h022, 8'h00},
    {2'd1, 9'h033, 8'h00},
    {2'd2, 9'h000, 8'h00},  // R5 commit
    {2'd3, 9'h023, 8'h11},
    {2'd3, 9'h024, 8'h22},
    {2'd3, 9'h025, 8'h33},
    {2'd3, 9'h022, 8'hFF},  // R6 untouched neighbour
    {2'd3, 9'h026, 8'hFF},
    {2'd0, 9'h13E, 8'h00},  // R4 wrap session
    {2'd1, 9'h0A1, 8'h00},
    {2'd1, 9'h0A2, 8'h00},
    {2'd1, 9'h0A3, 8'h00},
    {2'd2, 9'h000, 8'h00},
    {2'd3, 9'h13E, 8'hA1},
    {2'd3, 9'h13F, 8'hA2},
    {2'd3, 9'h130, 8'hA3},
    {2'd3, 9'h131, 8'hFF}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic do_base(input logic [AW-1:0] a);
    base_addr = a; load_base = 1'b1; cyc(); load_base = 1'b0;
  endtask

  task automatic do_byte(input logic [DW-1:0] d);
    byte_data = d; byte_stb = 1'b1; cyc(); byte_stb = 1'b0;
  endtask

  // pulse stop and return the number of cycles busy stayed high
  task automatic do_stop(output int n);
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    n = 0;
    while (busy && n < WR + 10) begin
      n++;
      cyc();
    end
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    rd_addr = a; #1;
    chk(req, rd_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n, w0;
    sess_start = 0; load_base = 0; byte_stb = 0; stop_stb = 0; wp_abort = 0;
    base_addr = '0; byte_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 busy during power-up", busy, 1);
    rd_chk("R2 erased low", 9'h000, 8'hFF);
    rd_chk("R2 erased high", 9'h1FF, 8'hFF);
    // R1: a STOP with bytes offered during power-up must not be taken
    do_byte(8'h5C);
    repeat (PU) cyc();
    chk("R1 busy released", busy, 0);
    do_stop(n);
    chk("R1 no command taken while powering up", n, 0);

    // vector table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [8:0] v;
      logic [7:0] e;
      {op, v, e} = VEC[i];
      case (op)
        2'd0: do_base(v);
        2'd1: do_byte(v[7:0]);
        2'd2: begin
          w0 = we_cnt;
          do_stop(n);
          chk("R5 write cycle length", n, WR);
          chk("R6 one write per loaded slot", we_cnt - w0, 3);
        end
        default: rd_chk("R3/R4/R5 table readback", v, e);
      endcase
    end

    // R4: seventeen bytes overwrite slot 0
    do_base(9'h100);
    for (int k = 0; k < 17; k++) do_byte(8'(8'h40 + k));
    w0 = we_cnt;
    do_stop(n);
    chk("R4 full page writes", we_cnt - w0, 16);
    rd_chk("R4 overwritten slot", 9'h100, 8'h50);
    rd_chk("R4 next slot", 9'h101, 8'h41);
    rd_chk("R4 last slot", 9'h10F, 8'h4F);

    // R7: address-only session
    do_base(9'h040);
    w0 = we_cnt;
    do_stop(n);
    chk("R7 no busy on empty stop", n, 0);
    chk("R7 no write on empty stop", we_cnt - w0, 0);

    // R8: START abandons
    do_base(9'h050);
    do_byte(8'h77);
    sess_start = 1; cyc(); sess_start = 0;
    do_stop(n);
    chk("R8 abandoned no busy", n, 0);
    rd_chk("R8 array unchanged", 9'h050, 8'hFF);

    // R9: write protect abandons
    do_base(9'h060);
    do_byte(8'h88);
    wp_abort = 1; cyc(); wp_abort = 0;
    w0 = we_cnt;
    do_stop(n);
    chk("R9 refused no busy", n, 0);
    chk("R9 refused no write", we_cnt - w0, 0);
    rd_chk("R9 array unchanged", 9'h060, 8'hFF);

    // R10: inputs while busy are ignored
    do_base(9'h070);
    do_byte(8'h5A);
    stop_stb = 1; cyc(); stop_stb = 0;
    do_base(9'h080);
    do_byte(8'h66);
    sess_start = 1; cyc(); sess_start = 0;
    repeat (WR + 2) cyc();
    chk("R10 idle again", busy, 0);
    do_stop(n);
    chk("R10 nothing pending after busy", n, 0);
    rd_chk("R10 busy byte not stored", 9'h080, 8'hFF);
    rd_chk("R10 busy start did not cancel", 9'h070, 8'h5A);

    // R11: byte and STOP in the same cycle
    do_base(9'h090);
    do_byte(8'h01);
    byte_data = 8'h02; byte_stb = 1; stop_stb = 1; cyc(); byte_stb = 0; stop_stb = 0;
    n = 0;
    while (busy && n < WR + 10) begin n++; cyc(); end
    chk("R11 commit length", n, WR);
    rd_chk("R11 coincident byte", 9'h091, 8'h02);
    rd_chk("R11 earlier byte", 9'h090, 8'h01);

    // R12: byte and START / abort in the same cycle
    do_base(9'h0A0);
    do_byte(8'h10);
    byte_data = 8'h20; byte_stb = 1; sess_start = 1; cyc(); byte_stb = 0; sess_start = 0;
    do_stop(n);
    chk("R12 start with byte no busy", n, 0);
    rd_chk("R12 dropped byte", 9'h0A1, 8'hFF);
    do_base(9'h0B0);
    byte_data = 8'h30; byte_stb = 1; wp_abort = 1; cyc(); byte_stb = 0; wp_abort = 0;
    w0 = we_cnt;
    do_stop(n);
    chk("R12 abort with byte no write", we_cnt - w0, 0);
    rd_chk("R12 abort byte dropped", 9'h0B0, 8'hFF);

    finished = 1;
    summary();
    $finish;
  end
endmodule